// File: doc/BRIEF.md
# Store-Miss Write-Combining Buffer

This block sits next to a cache that allocates lines only on load misses. Stores that miss that cache come here instead. They never cause a cache line to be allocated. The buffer keeps a small ring of line-sized entries, four by default. Each entry holds a line address, a full 64-byte data line and one valid bit per byte. A store to a line that already has an open entry is merged into that entry. A store to any other line opens the next free entry. Entries leave the buffer as single write transactions on a request/ready memory port. Each transaction carries the line address, the data line and the per-byte valid mask as byte enables.

Loads can probe the buffer with a line address. On a hit the probe returns the merged data and the mask of bytes that are present. The requester then fetches any missing bytes from memory. Draining always takes the oldest entry. A drain starts for one of three reasons:
- some entry has every byte written;
- a store to a new line finds the ring full;
- the flush input is high.

The drain controller has three states:
- `S_IDLE`: no request is presented.
- `S_DRAIN`: a single drain; the oldest entry is held on the memory port.
- `S_FLUSH`: a flush drain; entries are presented back to back.

The transitions are:
- `IDLE->FLUSH` when flush is high and the ring is not empty.
- `IDLE->DRAIN` when the ring is not empty and either some entry is full or a waiting store needs a slot.
- `DRAIN->IDLE` on the memory handshake.
- `FLUSH->FLUSH` on a handshake while flush is still high and more than one entry remains.
- `FLUSH->IDLE` on a handshake otherwise.

Top module: `store_miss_wcb`

## Requirements
- R1: A store whose line has no open entry is accepted into a new entry while fewer than NUM_ENT entries are open. Entries are taken in ring order.
- R2: A store whose line matches an open entry merges its bytes into that entry. It opens no new entry, and a later write to a byte overwrites the earlier value.
- R3: st_size selects the store width: code 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. Byte k of st_data lands at line offset st_addr[5:0]+k, and st_addr[ADDR_W-1:6] is the line address.
- R4: A drain presents the entry's line address, its data and its byte mask as mem_be. Bytes never written read as zero. All of these stay stable while mem_req_valid is high and mem_req_ready is low.
- R5: When any open entry has all 64 mask bits set, a drain of the oldest entry starts on the next cycle.
- R6: A store to a new line while all entries are open is stalled (st_ready low). The oldest entry drains, and the store is accepted after the slot frees.
- R7: Entries drain strictly oldest first.
- R8: A store to the line currently presented on the memory port is stalled until that drain completes. It is then accepted into a fresh entry and is not lost.
- R9: While flush is high, st_ready is low and entries drain back to back until the ring is empty.
- R10: A probe with ld_line returns ld_hit, the byte mask of the matching entry and its data, with absent bytes zero. An entry stays visible until its drain handshake.
- R11: After reset st_ready is high, mem_req_valid is low and no probe hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store-miss request |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | ADDR_W | Byte address of the store, naturally aligned |
| st_size | input | 2 | Store width code (1/2/4/8 bytes) |
| st_data | input | ST_BYTES*8 | Store data, byte 0 at the lowest address |
| flush | input | 1 | Drain everything while high |
| ld_line | input | ADDR_W-6 | Line address of a load probe |
| ld_hit | output | 1 | Probe matched an open entry |
| ld_mask | output | LINE_BYTES | Bytes present in the matching entry |
| ld_data | output | LINE_BYTES*8 | Merged data of the matching entry |
| mem_req_valid | output | 1 | Drain write request |
| mem_req_ready | input | 1 | Memory accepts the write |
| mem_line | output | ADDR_W-6 | Line address of the write |
| mem_be | output | LINE_BYTES | Byte enables of the write |
| mem_data | output | LINE_BYTES*8 | Write data line |

## Verification
The hardest situation to reach is a store aimed at the very line being drained while memory withholds ready. A store that arrives one cycle too early is merged before the drain begins, so the stall never shows. The bench first fills a line completely with ready held low. It then waits two cycles so the controller is in the drain state before it issues the store, and releases ready only later. A long random phase with a handful of lines, random ready and one-cycle flush pulses then mixes merges, evictions and drains of a full entry. A behavioural model checks every cycle.

// File: rtl/smw_pkg.sv
package smw_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_DRAIN = 2'd1,
        S_FLUSH = 2'd2
    } drain_state_e;
endpackage

// File: rtl/smw_lane_place.sv
module smw_lane_place #(
    parameter int LINE_BYTES = 64,
    parameter int ST_BYTES   = 8,
    parameter int OFF_W      = 6
) (
    input  logic [OFF_W-1:0]        off_i,
    input  logic [1:0]              size_i,
    input  logic [ST_BYTES*8-1:0]   data_i,
    output logic [LINE_BYTES-1:0]   be_o,
    output logic [LINE_BYTES*8-1:0] data_o
);
    always_comb begin
        int nb;
        logic [OFF_W-1:0] pos;
        be_o   = '0;
        data_o = '0;
        nb     = 1 << size_i;
        for (int k = 0; k < ST_BYTES; k++) begin
            pos = off_i + OFF_W'(k);
            if (k < nb) begin
                be_o[pos]          = 1'b1;
                data_o[pos*8 +: 8] = data_i[k*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/smw_entry.sv
module smw_entry #(
    parameter int LINE_W     = 26,
    parameter int LINE_BYTES = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_i,
    input  logic                    merge_i,
    input  logic                    free_i,
    input  logic [LINE_W-1:0]       line_i,
    input  logic [LINE_BYTES-1:0]   be_i,
    input  logic [LINE_BYTES*8-1:0] data_i,
    output logic                    valid_o,
    output logic                    full_o,
    output logic [LINE_W-1:0]       line_o,
    output logic [LINE_BYTES-1:0]   mask_o,
    output logic [LINE_BYTES*8-1:0] data_o
);
    logic                    valid_q;
    logic [LINE_W-1:0]       line_q;
    logic [LINE_BYTES-1:0]   mask_q;
    logic [LINE_BYTES*8-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            line_q  <= '0;
            mask_q  <= '0;
            data_q  <= '0;
        end else if (alloc_i) begin
            valid_q <= 1'b1;
            line_q  <= line_i;
            mask_q  <= be_i;
            data_q  <= data_i;
        end else if (free_i) begin
            valid_q <= 1'b0;
            mask_q  <= '0;
            data_q  <= '0;
        end else if (merge_i) begin
            mask_q <= mask_q | be_i;
            for (int b = 0; b < LINE_BYTES; b++) begin
                if (be_i[b]) data_q[b*8 +: 8] <= data_i[b*8 +: 8];
            end
        end
    end

    assign valid_o = valid_q;
    assign full_o  = valid_q && (&mask_q);
    assign line_o  = line_q;
    assign mask_o  = mask_q;
    assign data_o  = data_q;

    AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> !valid_q); // R1
    AST_MERGE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        merge_i |-> valid_q && !free_i); // R2
endmodule

// File: rtl/smw_drain_fsm.sv
module smw_drain_fsm
    import smw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush_i,
    input  logic nonempty_i,
    input  logic last_i,
    input  logic any_full_i,
    input  logic need_slot_i,
    input  logic ready_i,
    output logic req_o,
    output logic pop_o
);
    drain_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (flush_i && nonempty_i)
                    state_d = S_FLUSH;
                else if (nonempty_i && (any_full_i || need_slot_i))
                    state_d = S_DRAIN;
            end
            S_DRAIN: begin
                if (ready_i) state_d = S_IDLE;
            end
            S_FLUSH: begin
                if (ready_i) state_d = (flush_i && !last_i) ? S_FLUSH : S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            S_DRAIN, S_FLUSH: req_o = 1'b1;
            default:          req_o = 1'b0;
        endcase
        pop_o = req_o && ready_i;
    end

    AST_FULL_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !flush_i && any_full_i) |=> state_q == S_DRAIN); // R5
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ready_i) |=> req_o); // R4
endmodule

// File: rtl/store_miss_wcb.sv
module store_miss_wcb #(
    parameter int ADDR_W     = 32,
    parameter int NUM_ENT    = 4,
    parameter int LINE_BYTES = 64,
    parameter int ST_BYTES   = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   st_valid,
    output logic                                   st_ready,
    input  logic [ADDR_W-1:0]                      st_addr,
    input  logic [1:0]                             st_size,
    input  logic [ST_BYTES*8-1:0]                  st_data,
    input  logic                                   flush,
    input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   ld_line,
    output logic                                   ld_hit,
    output logic [LINE_BYTES-1:0]                  ld_mask,
    output logic [LINE_BYTES*8-1:0]                ld_data,
    output logic                                   mem_req_valid,
    input  logic                                   mem_req_ready,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   mem_line,
    output logic [LINE_BYTES-1:0]                  mem_be,
    output logic [LINE_BYTES*8-1:0]                mem_data
);
    localparam int OFF_W     = $clog2(LINE_BYTES);
    localparam int LINE_W    = ADDR_W - OFF_W;
    localparam int LINE_BITS = LINE_BYTES * 8;
    localparam int IDX_W     = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
    localparam int CNT_W     = $clog2(NUM_ENT + 1);

    function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(NUM_ENT - 1)) ? '0 : p + 1'b1;
    endfunction

    logic [LINE_W-1:0]     st_line;
    logic [LINE_BYTES-1:0] st_be;
    logic [LINE_BITS-1:0]  st_line_data;

    logic [NUM_ENT-1:0]    ent_valid, ent_full, st_hit, ld_hit_vec;
    logic [NUM_ENT-1:0]    alloc_vec, merge_vec, free_vec;
    logic [LINE_W-1:0]     ent_line [NUM_ENT];
    logic [LINE_BYTES-1:0] ent_mask [NUM_ENT];
    logic [LINE_BITS-1:0]  ent_data [NUM_ENT];

    logic [IDX_W-1:0] head_q, tail_q, match_idx;
    logic [CNT_W-1:0] count_q;
    logic             any_match, ring_full, head_blocked;
    logic             do_alloc, do_merge, pop, busy;

    assign st_line = st_addr[ADDR_W-1:OFF_W];

    smw_lane_place #(
        .LINE_BYTES(LINE_BYTES), .ST_BYTES(ST_BYTES), .OFF_W(OFF_W)
    ) u_place (
        .off_i (st_addr[OFF_W-1:0]),
        .size_i(st_size),
        .data_i(st_data),
        .be_o  (st_be),
        .data_o(st_line_data)
    );

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        assign alloc_vec[i] = do_alloc && (tail_q == IDX_W'(i));
        assign merge_vec[i] = do_merge && st_hit[i];
        assign free_vec[i]  = pop && (head_q == IDX_W'(i));

        smw_entry #(.LINE_W(LINE_W), .LINE_BYTES(LINE_BYTES)) u_entry (
            .clk    (clk),
            .rst_n  (rst_n),
            .alloc_i(alloc_vec[i]),
            .merge_i(merge_vec[i]),
            .free_i (free_vec[i]),
            .line_i (st_line),
            .be_i   (st_be),
            .data_i (st_line_data),
            .valid_o(ent_valid[i]),
            .full_o (ent_full[i]),
            .line_o (ent_line[i]),
            .mask_o (ent_mask[i]),
            .data_o (ent_data[i])
        );

        assign st_hit[i]     = ent_valid[i] && (ent_line[i] == st_line);
        assign ld_hit_vec[i] = ent_valid[i] && (ent_line[i] == ld_line);
    end

    always_comb begin
        match_idx = '0;
        ld_mask   = '0;
        ld_data   = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (st_hit[i]) match_idx = IDX_W'(i);
            if (ld_hit_vec[i]) begin
                ld_mask = ld_mask | ent_mask[i];
                ld_data = ld_data | ent_data[i];
            end
        end
    end

    assign ld_hit       = |ld_hit_vec;
    assign any_match    = |st_hit;
    assign ring_full    = (count_q == CNT_W'(NUM_ENT));
    assign head_blocked = busy && (match_idx == head_q);
    assign st_ready     = !flush && (any_match ? !head_blocked : !ring_full);
    assign do_merge     = st_valid && st_ready && any_match;
    assign do_alloc     = st_valid && st_ready && !any_match;

    smw_drain_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush),
        .nonempty_i (count_q != '0),
        .last_i     (count_q == CNT_W'(1)),
        .any_full_i (|ent_full),
        .need_slot_i(st_valid && !any_match && ring_full),
        .ready_i    (mem_req_ready),
        .req_o      (busy),
        .pop_o      (pop)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (do_alloc) tail_q <= ring_next(tail_q);
            if (pop)      head_q <= ring_next(head_q);
            case ({do_alloc, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign mem_req_valid = busy;
    assign mem_line      = ent_line[head_q];
    assign mem_be        = ent_mask[head_q];
    assign mem_data      = ent_data[head_q];

    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_hit)); // R2
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            ($stable(mem_line) && $stable(mem_be) && $stable(mem_data))); // R4
    AST_DRAIN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> ent_valid[head_q]); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        do_alloc |-> !ent_valid[tail_q]); // R6
endmodule

// File: tb/store_miss_wcb_tb.sv
module store_miss_wcb_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         st_valid = 1'b0;
    logic         st_ready;
    logic [31:0]  st_addr = '0;
    logic [1:0]   st_size = '0;
    logic [63:0]  st_data = '0;
    logic         flush = 1'b0;
    logic [25:0]  ld_line = '0;
    logic         ld_hit;
    logic [63:0]  ld_mask;
    logic [511:0] ld_data;
    logic         mem_req_valid;
    logic         mem_req_ready = 1'b0;
    logic [25:0]  mem_line;
    logic [63:0]  mem_be;
    logic [511:0] mem_data;

    store_miss_wcb u_dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_size(st_size), .st_data(st_data), .flush(flush),
        .ld_line(ld_line), .ld_hit(ld_hit), .ld_mask(ld_mask), .ld_data(ld_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_line(mem_line), .mem_be(mem_be), .mem_data(mem_data)
    );

    always #4 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [25:0]  m_line [$];
    logic [63:0]  m_mask [$];
    logic [511:0] m_data [$];
    int           m_state = 0;
    logic [25:0]  got_line [$];
    logic [63:0]  got_be [$];

    bit          rand_mode = 1'b0;
    bit          ready_fixed = 1'b0;
    bit          flush_fixed = 1'b0;
    logic [25:0] probe_fixed = '0;

    task automatic check(input bit ok, input string tag, input logic [511:0] act,
                         input logic [511:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h @%0t", tag, act, exp, $time);
        end
    endtask

    function automatic void place(input logic [31:0] a, input logic [1:0] sz,
                                  input logic [63:0] d, output logic [63:0] be,
                                  output logic [511:0] ld);
        be = '0;
        ld = '0;
        for (int k = 0; k < (1 << sz); k++) begin
            be[a[5:0] + k] = 1'b1;
            ld[(a[5:0] + k)*8 +: 8] = d[k*8 +: 8];
        end
    endfunction

    // stimulus driver for ready, flush and probe
    always @(posedge clk) begin
        #1;
        if (rand_mode) begin
            mem_req_ready = ($urandom_range(0, 2) != 0);
            flush         = ($urandom_range(0, 59) == 0);
            ld_line       = 26'h40 + 26'($urandom_range(0, 5));
        end else begin
            mem_req_ready = ready_fixed;
            flush         = flush_fixed;
            ld_line       = probe_fixed;
        end
    end

    // behavioural reference, compared every cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int j, k, cnt;
            bit exp_ready, exp_mv, fire, pop, anyfull;
            logic [63:0]  be;
            logic [511:0] ld, tmp, pd;
            logic [63:0]  pm;
            cnt = m_line.size();
            j = -1;
            k = -1;
            foreach (m_line[i]) begin
                if (m_line[i] == st_addr[31:6]) j = i;
                if (m_line[i] == ld_line) k = i;
            end
            exp_ready = !flush && ((j >= 0) ? !(j == 0 && m_state != 0) : (cnt < N));
            exp_mv = (m_state != 0);
            check(st_ready == exp_ready, "st_ready R1 R6 R8 R9", 512'(st_ready), 512'(exp_ready));
            check(mem_req_valid == exp_mv, "mem_req_valid R5 R6 R9", 512'(mem_req_valid), 512'(exp_mv));
            if (exp_mv) begin
                check(mem_line == m_line[0], "mem_line R7", 512'(mem_line), 512'(m_line[0]));
                check(mem_be == m_mask[0], "mem_be R4", 512'(mem_be), 512'(m_mask[0]));
                check(mem_data == m_data[0], "mem_data R4", mem_data, m_data[0]);
            end
            pm = (k >= 0) ? m_mask[k] : '0;
            pd = (k >= 0) ? m_data[k] : '0;
            check(ld_hit == (k >= 0), "ld_hit R10", 512'(ld_hit), 512'(k >= 0));
            check(ld_mask == pm, "ld_mask R2 R3 R10", 512'(ld_mask), 512'(pm));
            check(ld_data == pd, "ld_data R2 R3 R10", ld_data, pd);

            fire = st_valid && exp_ready;
            pop  = exp_mv && mem_req_ready;
            if (pop) begin
                got_line.push_back(mem_line);
                got_be.push_back(mem_be);
            end
            anyfull = 1'b0;
            foreach (m_mask[i]) if (&m_mask[i]) anyfull = 1'b1;
            case (m_state)
                0: begin
                    if (flush && cnt != 0) m_state = 2;
                    else if (cnt != 0 && (anyfull || (st_valid && j < 0 && cnt == N)))
                        m_state = 1;
                end
                1: if (pop) m_state = 0;
                default: if (pop) m_state = (flush && cnt > 1) ? 2 : 0;
            endcase
            place(st_addr, st_size, st_data, be, ld);
            if (fire) begin
                if (j >= 0) begin
                    tmp = m_data[j];
                    for (int b = 0; b < 64; b++) if (be[b]) tmp[b*8 +: 8] = ld[b*8 +: 8];
                    m_data[j] = tmp;
                    m_mask[j] = m_mask[j] | be;
                end else begin
                    m_line.push_back(st_addr[31:6]);
                    m_mask.push_back(be);
                    m_data.push_back(ld);
                end
            end
            if (pop) begin
                void'(m_line.pop_front());
                void'(m_mask.pop_front());
                void'(m_data.pop_front());
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic store(input logic [31:0] a, input logic [1:0] sz, input logic [63:0] d,
                         output int stalls);
        stalls = 0;
        st_valid = 1'b1;
        st_addr = a;
        st_size = sz;
        st_data = d;
        @(negedge clk);
        while (!st_ready) begin
            stalls++;
            @(negedge clk);
        end
        @(posedge clk);
        #1;
        st_valid = 1'b0;
    endtask

    task automatic probe(input logic [25:0] line, input bit eh, input logic [63:0] em,
                         input string tag);
        probe_fixed = line;
        step(2);
        @(negedge clk);
        check(ld_hit == eh, tag, 512'(ld_hit), 512'(eh));
        check(ld_mask == em, tag, 512'(ld_mask), 512'(em));
        step(1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired act=hang exp=finish");
        finish_run();
    end

    initial begin
        int s;
        step(4);
        rst_n = 1'b1;
        @(negedge clk);
        check(st_ready == 1'b1, "reset st_ready R11", 512'(st_ready), 512'(1));
        check(mem_req_valid == 1'b0, "reset mem_req_valid R11", 512'(mem_req_valid), 512'(0));
        check(ld_hit == 1'b0, "reset ld_hit R11", 512'(ld_hit), 512'(0));
        step(1);

        // R3 placement of a 2-byte store at offset 6
        store({26'h10, 6'd6}, 2'd1, 64'hBEEF, s);
        probe(26'h10, 1'b1, 64'h00C0, "size2 mask R3");
        // R2 merge of a 4-byte store and an overwrite
        store({26'h10, 6'd8}, 2'd2, 64'h11223344, s);
        store({26'h10, 6'd6}, 2'd0, 64'h5A, s);
        probe(26'h10, 1'b1, 64'h0FC0, "merge mask R2");
        check(ld_data[6*8 +: 8] == 8'h5A, "overwrite byte R2", 512'(ld_data[6*8 +: 8]), 512'(8'h5A));
        // R1 allocation of three more lines
        store({26'h11, 6'd0}, 2'd3, 64'h0102030405060708, s);
        store({26'h12, 6'd16}, 2'd3, 64'hA5A5A5A5A5A5A5A5, s);
        store({26'h13, 6'd63}, 2'd0, 64'h77, s);
        probe(26'h13, 1'b1, 64'h8000_0000_0000_0000, "fourth entry R1");
        // R6 R7 a fifth line evicts the oldest
        ready_fixed = 1'b1;
        store({26'h14, 6'd0}, 2'd0, 64'h01, s);
        check(s > 0, "new line stalls when full R6", 512'(s), 512'(1));
        check(got_line.size() >= 1 && got_line[0] == 26'h10, "oldest first R7",
              512'(got_line[0]), 512'(26'h10));
        probe(26'h14, 1'b1, 64'h1, "slot reused R6");
        // R9 flush drains everything
        flush_fixed = 1'b1;
        step(20);
        flush_fixed = 1'b0;
        step(2);
        check(got_line.size() == 5, "flush drained all R9", 512'(got_line.size()), 512'(5));
        probe(26'h12, 1'b0, 64'h0, "flushed line gone R9");
        // R5 a fully written line drains by itself
        for (int w = 0; w < 8; w++) store({26'h20, 6'(w*8)}, 2'd3, 64'h1111_0000 + 64'(w), s);
        step(4);
        check(got_line.size() == 6 && got_line[5] == 26'h20, "full line drains R5",
              512'(got_line[got_line.size()-1]), 512'(26'h20));
        check(got_be[got_be.size()-1] == '1, "full byte enables R4",
              512'(got_be[got_be.size()-1]), 512'(64'hFFFF_FFFF_FFFF_FFFF));
        // R8 store to the line held on the memory port
        ready_fixed = 1'b0;
        for (int w = 0; w < 8; w++) store({26'h21, 6'(w*8)}, 2'd3, 64'h2222_0000 + 64'(w), s);
        step(3);
        fork
            store({26'h21, 6'd4}, 2'd2, 64'hCAFEF00D, s);
            begin step(10); ready_fixed = 1'b1; end
        join
        check(s >= 5, "store to draining line stalls R8", 512'(s), 512'(5));
        probe(26'h21, 1'b1, 64'h0000_00F0, "stalled store kept R8");
        flush_fixed = 1'b1;
        step(6);
        flush_fixed = 1'b0;
        step(2);

        // random mix of lines, sizes, ready and flush pulses
        rand_mode = 1'b1;
        for (int it = 0; it < 1500; it++) begin
            logic [1:0] sz;
            logic [5:0] off;
            sz  = 2'($urandom_range(0, 3));
            off = 6'($urandom_range(0, 63)) & ~6'((1 << sz) - 1);
            store({26'h40 + 26'($urandom_range(0, 5)), off}, sz,
                  {$urandom, $urandom}, s);
            if ($urandom_range(0, 3) == 0) step(1);
        end
        rand_mode = 1'b0;
        step(5);
        finish_run();
    end
endmodule